// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the master side of a two-wire PHY management link. A host asks for one register access at a time. It supplies a direction (read or write), a 5-bit PHY address, a 5-bit register address, 16 bits of write data and a clock divisor, and then pulses `start`. The block sends a complete serial frame on the line. The frame is a run of ones, a start pattern, an opcode, the two addresses, a two-bit turnaround gap and a 16-bit data field. At the end of the frame the block pulses `done`. After a read, the captured register contents appear on `rdata`.

The management clock `mdc` is made from the system clock. Each half period lasts `mdc_half + 1` system clocks. Outgoing bits change only while `mdc` is low, and incoming bits are sampled at the rising edge. Three signals serve an external tristate pad: `mdio_o` carries the value to drive, `mdio_oe` enables the driver, and `mdio_i` returns the line level. The output enable is low whenever the block is idle. During a read it is also low from the first turnaround bit to the end of the frame, so the PHY can take the line without contention. `mdio_i` passes through `SYNC_STAGES` flops before it is sampled, so `mdc_half` must be at least `SYNC_STAGES`.

Top module: `mdio_master`

## Requirements
- R1: While reset is held, `busy`, `done`, `mdc` and `mdio_oe` are 0 and `rdata` is 0.
- R2: A `start` seen while idle is accepted at that clock edge. From the next cycle `busy` is 1, `mdc` is low and the first frame bit (a 1) is driven with `mdio_oe` high.
- R3: The frame bits go out in this order: 32 ones; then 0 and 1; then the opcode, which is 1,0 when `op_read`=1 and 0,1 when `op_read`=0; then `phy_addr` MSB first; then `reg_addr` MSB first; then two turnaround bits; then 16 data bits, starting with bit 15.
- R4: A frame lasts 64 bit times. Each bit time is `mdc` low for `mdc_half+1` clocks and then high for `mdc_half+1` clocks. `mdc` stays low while idle.
- R5: `mdio_o` changes only while `mdc` is low. It is steady through every high phase.
- R6: A write drives the turnaround bits as 1 then 0, holds `mdio_oe` high for the whole frame, and sends `wdata` in the data field.
- R7: During a read, `mdio_oe` is 0 from the first turnaround bit (bit 46) until the end of the frame.
- R8: During a read, `mdio_i` is sampled at each rising edge of `mdc` in the data field, bit 15 first, and the result is placed on `rdata` in the `done` cycle. `rdata` then holds until the next read completes, and a write leaves it unchanged.
- R9: The frame ends with `done` high for exactly one clock. In that cycle `busy`, `mdc` and `mdio_oe` are all 0.
- R10: A `start` that arrives while `busy` is high is ignored. The running frame keeps its original fields.
- R11: A `start` in the `done` cycle is accepted, and a new frame begins on the next cycle.
- R12: `mdc_half` is captured when a frame is accepted. Changing it during a frame does not alter that frame's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a frame |
| op_read | input | 1 | 1 = read access, 0 = write access |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Write data |
| mdc_half | input | DIV_W | MDC half period minus one, in system clocks |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock end-of-frame pulse |
| rdata | output | 16 | Data from the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Line value to drive |
| mdio_oe | output | 1 | Pad driver enable |
| mdio_i | input | 1 | Line level from the pad |

## Verification
The completion of one frame and the acceptance of the next can occur in the same clock. A frame's last falling edge, the `done` pulse and the loading of the shift registers for a new request all fall on adjacent edges. The bench raises `start` at the very half cycle in which it first sees `done`. A behavioural model, advanced clock by clock, then expects `busy` back high with `mdc` low and the first preamble bit driven one cycle later. The model also expects the previous read result to remain on `rdata` until the new read completes.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int PHY_AW = 5;
   localparam int REG_AW = 5;
   localparam int DATA_W = 16;
   // start, opcode, addresses, turnaround, data
   localparam int BODY_LEN = 2 + 2 + PHY_AW + REG_AW + 2 + DATA_W;

   localparam logic [1:0] SOF_PAT = 2'b01;
   localparam logic [1:0] OPC_RD  = 2'b10;
   localparam logic [1:0] OPC_WR  = 2'b01;
   localparam logic [1:0] TA_WR   = 2'b10;

   typedef struct packed {
      logic              rd;
      logic [PHY_AW-1:0] phy;
      logic [REG_AW-1:0] regad;
      logic [DATA_W-1:0] wdata;
   } mgmt_req_t;
endpackage

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   generate
      if (STAGES == 0) begin : g_pass
         assign d_out = d_in;
      end else begin : g_flops
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '1;
            else if (STAGES == 1) chain_q <= d_in;
            else chain_q <= {chain_q[STAGES-2:0], d_in};
         end
         assign d_out = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [DIV_W-1:0] half_in,
   output logic             mdc,
   output logic             rise_stb,
   output logic             fall_stb
);
   logic [DIV_W-1:0] half_q;
   logic [DIV_W-1:0] cnt_q;
   logic             tick;

   assign tick     = run && (cnt_q == half_q);
   assign rise_stb = tick && !mdc;
   assign fall_stb = tick && mdc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         half_q <= '0;
         cnt_q  <= '0;
         mdc    <= 1'b0;
      end else if (restart) begin
         half_q <= half_in;
         cnt_q  <= '0;
         mdc    <= 1'b0;
      end else if (run) begin
         if (tick) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else begin
         cnt_q <= '0;
         mdc   <= 1'b0;
      end
   end

   // R4
   mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !restart) |=> !mdc);
   // R12
   half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !restart) |-> $stable(half_q));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  mgmt_req_t         req,
   input  logic              rise_stb,
   input  logic              fall_stb,
   input  logic              din,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              dout,
   output logic              doe
);
   localparam int FRAME_LEN = PRE_LEN + BODY_LEN;
   localparam int CW        = $clog2(FRAME_LEN);
   localparam int TA_POS    = PRE_LEN + 4 + PHY_AW + REG_AW;
   localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_LEN - 1);
   localparam logic [CW-1:0] TA_BIT   = CW'(TA_POS);

   logic [FRAME_LEN-1:0] sh_q, oe_q, frame_d, mask_d;
   logic [CW-1:0]        bit_q;
   logic                 rd_q;
   logic [DATA_W-1:0]    cap_q;

   always_comb begin
      frame_d = {{PRE_LEN{1'b1}}, SOF_PAT,
                 req.rd ? OPC_RD : OPC_WR,
                 req.phy, req.regad,
                 req.rd ? 2'b00 : TA_WR,
                 req.rd ? {DATA_W{1'b0}} : req.wdata};
      mask_d  = req.rd ? {{TA_POS{1'b1}}, {(FRAME_LEN-TA_POS){1'b0}}}
                       : {FRAME_LEN{1'b1}};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         oe_q  <= '0;
         bit_q <= '0;
         rd_q  <= 1'b0;
         busy  <= 1'b0;
         done  <= 1'b0;
         cap_q <= '0;
         rdata <= '0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            sh_q  <= frame_d;
            oe_q  <= mask_d;
            bit_q <= '0;
            rd_q  <= req.rd;
            busy  <= 1'b1;
         end else if (busy) begin
            if (rise_stb && rd_q) cap_q <= {cap_q[DATA_W-2:0], din};
            if (fall_stb) begin
               if (bit_q == LAST_BIT) begin
                  busy <= 1'b0;
                  done <= 1'b1;
                  sh_q <= '0;
                  oe_q <= '0;
                  if (rd_q) rdata <= cap_q;
               end else begin
                  bit_q <= bit_q + 1'b1;
                  sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b0};
                  oe_q  <= {oe_q[FRAME_LEN-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign dout = sh_q[FRAME_LEN-1];
   assign doe  = oe_q[FRAME_LEN-1];

   // R7
   ta_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_q && bit_q >= TA_BIT) |-> !doe);
   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !doe));
   // R1
   idle_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !doe);
   // R10
   kind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(rd_q));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int PRE_LEN     = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op_read,
   input  logic [PHY_AW-1:0] phy_addr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DIV_W-1:0]  mdc_half,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   generate
      if (PRE_LEN < 1 || PRE_LEN > 32) begin : g_bad_pre
         $error("PRE_LEN must lie in 1..32");
      end
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("DIV_W must lie in 1..16");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..3");
      end
   endgenerate

   mgmt_req_t req;
   logic      accept, rise_stb, fall_stb, din_s;

   assign req    = '{rd: op_read, phy: phy_addr, regad: reg_addr, wdata: wdata};
   assign accept = start && !busy;

   mdio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(mdio_i), .d_out(din_s));

   mdio_clk_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .restart(accept), .run(busy),
      .half_in(mdc_half), .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb));

   mdio_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
      .clk(clk), .rst_n(rst_n), .accept(accept), .req(req),
      .rise_stb(rise_stb), .fall_stb(fall_stb), .din(din_s),
      .busy(busy), .done(done), .rdata(rdata), .dout(mdio_o), .doe(mdio_oe));

   // R5
   hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mdc) |-> $stable(mdio_o));
   // R2
   accept_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !mdc && mdio_oe && mdio_o));
   // R4
   idle_mdc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> !mdc);
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
   localparam int DIV_W = 8;
   localparam int FR    = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        start = 1'b0, op_read = 1'b0, mdio_i = 1'b1;
   logic [4:0]  phy_addr = '0, reg_addr = '0;
   logic [15:0] wdata = '0;
   logic [7:0]  mdc_half = 8'd2;
   wire         busy, done, mdc, mdio_o, mdio_oe;
   wire  [15:0] rdata;

   mdio_master #(.DIV_W(DIV_W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_read(op_read),
      .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
      .mdc_half(mdc_half), .busy(busy), .done(done), .rdata(rdata),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

   int checks = 0, fails = 0, cyc = 0;

   // reference model state
   bit          m_busy = 0, m_done = 0, m_read = 0;
   int          t = 0, mh = 0;
   logic [63:0] m_frame = '0;
   logic [15:0] m_rdata = '0, phy_val = '0;
   bit          prev_mdc = 0, prev_o = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] build(input bit rd, input logic [4:0] pa,
                                         input logic [4:0] ra, input logic [15:0] wd);
      bit q[$];
      logic [63:0] v;
      for (int i = 0; i < 32; i++) q.push_back(1'b1);
      q.push_back(1'b0); q.push_back(1'b1);
      q.push_back(rd); q.push_back(!rd);
      for (int i = 4; i >= 0; i--) q.push_back(pa[i]);
      for (int i = 4; i >= 0; i--) q.push_back(ra[i]);
      q.push_back(!rd); q.push_back(1'b0);
      for (int i = 15; i >= 0; i--) q.push_back(rd ? 1'b0 : wd[i]);
      for (int i = 0; i < 64; i++) v[63-i] = q[i];
      return v;
   endfunction

   function automatic int bit_of(input int tt, input int h);
      return (tt / (h + 1)) / 2;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_rdata = '0; t = 0;
      end else if (m_busy) begin
         m_done = 0;
         if (t == 2 * FR * (mh + 1) - 1) begin
            m_busy = 0; m_done = 1;
            if (m_read) m_rdata = phy_val;
         end else t++;
      end else begin
         m_done = 0;
         if (start) begin
            m_busy = 1; t = 0; mh = int'(mdc_half); m_read = op_read;
            m_frame = build(op_read, phy_addr, reg_addr, wdata);
         end
      end
      #2;
      if (rst_n) begin
         bit e_mdc, e_oe;
         int b;
         b     = m_busy ? bit_of(t, mh) : 0;
         e_mdc = m_busy ? bit'(((t / (mh + 1)) % 2)) : 1'b0;
         e_oe  = m_busy && (!m_read || b < 46);
         chk(busy == m_busy, "R2", "busy", busy, m_busy);
         chk(done == m_done, "R9", "done", done, m_done);
         chk(mdc == e_mdc, "R4", "mdc", mdc, e_mdc);
         chk(mdio_oe == e_oe, m_read ? "R7" : "R6", "mdio_oe", mdio_oe, e_oe);
         if (e_oe) chk(mdio_o == m_frame[63-b], "R3", "mdio_o", mdio_o, m_frame[63-b]);
         chk(rdata == m_rdata, "R8", "rdata", rdata, m_rdata);
         if (m_busy && mdc && prev_mdc)
            chk(mdio_o == prev_o, "R5", "mdio_o in high phase", mdio_o, prev_o);
         prev_mdc = mdc; prev_o = mdio_o;
      end
   end

   // PHY model: presents read data for the whole bit time
   always @(negedge clk) begin
      int b;
      b = bit_of(t, mh);
      mdio_i = (m_busy && m_read && b >= 48) ? phy_val[63-b] : 1'b1;
   end

   task automatic launch(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input logic [7:0] h, input logic [15:0] pv);
      phy_val = pv; op_read = rd; phy_addr = pa; reg_addr = ra;
      wdata = wd; mdc_half = h; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      int c0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 0 && done == 0 && mdc == 0 && mdio_oe == 0, "R1", "idle outputs",
          {busy, done, mdc, mdio_oe}, 0);
      chk(rdata == 16'h0, "R1", "rdata", rdata, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // write frame (R2, R3, R6)
      launch(1'b0, 5'h13, 5'h0A, 16'hA5C3, 8'd2, 16'h0);
      chk(busy && !mdc && mdio_oe && mdio_o, "R2", "first bit", {busy, mdc, mdio_oe, mdio_o}, 4'b1011);
      wait_done();
      chk(rdata == 16'h0, "R8", "rdata after write", rdata, 0);

      // read frame with ignored start and divisor change mid frame (R10, R12)
      @(negedge clk);
      c0 = cyc;
      launch(1'b1, 5'h05, 5'h11, 16'h0, 8'd3, 16'h5A96);
      repeat (200) @(negedge clk);
      op_read = 1'b0; phy_addr = 5'h1F; reg_addr = 5'h1F; wdata = 16'hFFFF;
      mdc_half = 8'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      chk(cyc - c0 == 1 + 2 * FR * 4, "R12", "frame length", cyc - c0, 1 + 2 * FR * 4);
      chk(rdata == 16'h5A96, "R10", "read data after ignored start", rdata, 16'h5A96);

      // start in the done cycle (R11)
      launch(1'b1, 5'h01, 5'h1F, 16'h0, 8'd2, 16'hC3E1);
      chk(busy && !done, "R11", "restart after done", {busy, done}, 2'b10);
      chk(rdata == 16'h5A96, "R8", "rdata held during new read", rdata, 16'h5A96);
      wait_done();
      chk(rdata == 16'hC3E1, "R8", "read data", rdata, 16'hC3E1);

      // write of zeros, slow clock; rdata kept
      @(negedge clk);
      launch(1'b0, 5'h00, 5'h00, 16'h0000, 8'd5, 16'h1234);
      wait_done();
      chk(rdata == 16'hC3E1, "R8", "rdata unchanged by write", rdata, 16'hC3E1);

      // read with start held high for a while (R10)
      @(negedge clk);
      launch(1'b1, 5'h1E, 5'h01, 16'h0, 8'd2, 16'hFFFF);
      start = 1'b1; phy_addr = 5'h00; op_read = 1'b0;
      repeat (40) @(negedge clk);
      start = 1'b0;
      wait_done();
      chk(rdata == 16'hFFFF, "R10", "read despite held start", rdata, 16'hFFFF);
      @(negedge clk);
      chk(!done && !busy && !mdio_oe, "R9", "quiet after done", {done, busy, mdio_oe}, 0);
      repeat (3) @(negedge clk);
      summary();
   end
endmodule